// File: doc/BRIEF.md
# Colour Palette Lookup with Sequenced Register Port

This block stores a 256-entry colour table. Each entry is an 18-bit colour made of three 6-bit parts: red, green and blue. A processor reaches the table through four byte-wide I/O registers. One register sets the index for loading. One sets the index for reading back. One data register moves colour parts one at a time. One status register tells which direction was selected last.

Behind the data register, a three-step sequencer walks through red, green and blue. Red and green values are held in staging registers until blue arrives. The whole entry is then written in one go, and the index moves on by itself, so a run of entries can be streamed after a single index write. Read-back works through a prefetch buffer that is loaded whenever the read index is set or moves on. A separate pixel port turns an 8-bit pixel value into an 18-bit colour on every clock.

Top module: `color_palette`

## Requirements
- R1: After reset, the load index is 0, the sequencer is at red, the status register reads 8'h00 and the pixel output is 0.
- R2: Data-register writes (offset 3C9h) supply red, then green, then blue. Only bits 5:0 of each byte are kept. The entry at the load index then holds {red, green, blue}, with red in bits 17:12 and blue in bits 5:0.
- R3: The palette does not change on the red or green write. The entry is written only when the blue write of a triplet arrives.
- R4: After each blue access while loading, the load index increments by one and wraps from 255 to 0. Reading offset 3C8h returns the current load index.
- R5: Writing offset 3C7h fetches that entry. Three data reads then return red, green and blue, each zero-extended to 8 bits. After blue, the read index increments (wrapping from 255 to 0) and the next entry is fetched.
- R6: Writing either index register (3C7h or 3C8h) restarts the sequencer at red, dropping a partly written triplet.
- R7: Reading offset 3C7h returns 8'h03 when the last index write went to 3C7h and 8'h00 when it went to 3C8h. Bits 7:2 are always zero.
- R8: The pixel port returns the entry for pix_idx one clock later. A committed entry shows up there on the clock after its blue write.
- R9: Data writes made while in read-back direction step the shared sequencer and the read index but never change the palette.
- R10: Reads from any offset other than 3C7h, 3C8h or 3C9h return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O register address |
| io_wr | input | 1 | Register write strobe, one access per cycle |
| io_rd | input | 1 | Register read strobe, ignored while io_wr is high |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the addressed register, valid in the strobe cycle |
| pix_idx | input | 8 | Pixel palette index |
| pix_rgb | output | 18 | Colour for pix_idx, {red, green, blue}, one cycle later |

## Verification
The bench targets these corner cases:
- **Partial triplet.** It watches the pixel output between the red, green and blue writes. A design that wrote each part as it arrived would show a half-updated colour too early.
- **Index wrap.** It streams two entries across the 255-to-0 boundary, for both loading and read-back. A counter that saturated or widened would put the second entry in the wrong slot.
- **Restart mid-triplet.** It rewrites an index register in the middle of a triplet. A sequencer that kept its phase would misplace the components.
- **Wrong-direction writes.** It issues data writes in read-back direction and confirms the palette is unchanged and the read index moved on.
- **Commit timing.** It samples the pixel output on the two cycles around a commit. A design that bypassed the write, or delayed it by another cycle, would be caught.

// File: rtl/pal_pkg.sv
`timescale 1ns/1ps
package pal_pkg;

   typedef enum logic [1:0] {
      PH_RED = 2'd0,
      PH_GRN = 2'd1,
      PH_BLU = 2'd2
   } phase_e;

   typedef enum logic {
      DIR_LOAD = 1'b0,
      DIR_READ = 1'b1
   } dir_e;

   // one-hot decoded register access for a single cycle
   typedef struct packed {
      logic ldi_wr;   // load-index write
      logic rdi_wr;   // read-index write
      logic dat_wr;   // data write
      logic ldi_rd;   // load-index readback
      logic sts_rd;   // status read
      logic dat_rd;   // data read
   } pal_acc_t;

endpackage

// File: rtl/pal_decode.sv
`timescale 1ns/1ps
module pal_decode
   import pal_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter logic [ADDR_W-1:0] LDI_ADDR = 16'h03C8,
   parameter logic [ADDR_W-1:0] RDI_ADDR = 16'h03C7,
   parameter logic [ADDR_W-1:0] DAT_ADDR = 16'h03C9
)(
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   output pal_acc_t          acc
);

   generate
      if (LDI_ADDR == RDI_ADDR || LDI_ADDR == DAT_ADDR || RDI_ADDR == DAT_ADDR) begin : g_bad_map
         $error("pal_decode: register addresses must be distinct");
      end
   endgenerate

   logic hit_ldi, hit_rdi, hit_dat, rd_only;

   always_comb begin
      hit_ldi = (io_addr == LDI_ADDR);
      hit_rdi = (io_addr == RDI_ADDR);
      hit_dat = (io_addr == DAT_ADDR);
      rd_only = io_rd & ~io_wr;

      acc.ldi_wr = io_wr   & hit_ldi;
      acc.rdi_wr = io_wr   & hit_rdi;
      acc.dat_wr = io_wr   & hit_dat;
      acc.ldi_rd = rd_only & hit_ldi;
      acc.sts_rd = rd_only & hit_rdi;
      acc.dat_rd = rd_only & hit_dat;
   end

endmodule

// File: rtl/pal_seq.sv
`timescale 1ns/1ps
module pal_seq
   import pal_pkg::*;
#(
   parameter int unsigned IDX_W  = 8,
   parameter int unsigned COMP_W = 6,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned RGB_W = 3 * COMP_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  pal_acc_t          acc,
   input  logic [DATA_W-1:0] wdata,
   input  logic [RGB_W-1:0]  fetch_rgb,
   output logic [IDX_W-1:0]  fetch_idx,
   output logic              commit_en,
   output logic [IDX_W-1:0]  commit_idx,
   output logic [RGB_W-1:0]  commit_rgb,
   output logic [IDX_W-1:0]  ldi_cur,
   output dir_e              dir,
   output logic [COMP_W-1:0] rd_comp
);

   generate
      if (IDX_W > DATA_W || COMP_W > DATA_W) begin : g_bad_width
         $error("pal_seq: index and component must fit in a data byte");
      end
   endgenerate

   phase_e             phase;
   dir_e               dir_q;
   logic [IDX_W-1:0]   ldi_q, rdi_q;
   logic [COMP_W-1:0]  stg_red, stg_grn;
   logic [RGB_W-1:0]   rbuf;

   logic data_acc, idx_load, third, load_step, read_step, prefetch;
   phase_e phase_nx;

   always_comb begin
      data_acc  = acc.dat_wr | acc.dat_rd;
      idx_load  = acc.ldi_wr | acc.rdi_wr;
      third     = data_acc & (phase == PH_BLU);
      load_step = third & (dir_q == DIR_LOAD);
      read_step = third & (dir_q == DIR_READ);
      prefetch  = acc.rdi_wr | read_step;
      fetch_idx = acc.rdi_wr ? wdata[IDX_W-1:0] : rdi_q + 1'b1;

      case (phase)
         PH_RED:  phase_nx = PH_GRN;
         PH_GRN:  phase_nx = PH_BLU;
         default: phase_nx = PH_RED;
      endcase

      commit_en  = load_step & acc.dat_wr;
      commit_idx = ldi_q;
      commit_rgb = {stg_red, stg_grn, wdata[COMP_W-1:0]};

      case (phase)
         PH_RED:  rd_comp = rbuf[RGB_W-1 -: COMP_W];
         PH_GRN:  rd_comp = rbuf[2*COMP_W-1 -: COMP_W];
         default: rd_comp = rbuf[COMP_W-1:0];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_RED;
         dir_q   <= DIR_LOAD;
         ldi_q   <= '0;
         rdi_q   <= '0;
         stg_red <= '0;
         stg_grn <= '0;
         rbuf    <= '0;
      end else begin
         if (idx_load)
            phase <= PH_RED;
         else if (data_acc)
            phase <= phase_nx;

         if (acc.ldi_wr)
            dir_q <= DIR_LOAD;
         else if (acc.rdi_wr)
            dir_q <= DIR_READ;

         if (acc.ldi_wr)
            ldi_q <= wdata[IDX_W-1:0];
         else if (load_step)
            ldi_q <= ldi_q + 1'b1;

         if (acc.rdi_wr)
            rdi_q <= wdata[IDX_W-1:0];
         else if (read_step)
            rdi_q <= rdi_q + 1'b1;

         if (acc.dat_wr && phase == PH_RED)
            stg_red <= wdata[COMP_W-1:0];
         if (acc.dat_wr && phase == PH_GRN)
            stg_grn <= wdata[COMP_W-1:0];

         if (prefetch)
            rbuf <= fetch_rgb;
      end
   end

   assign ldi_cur = ldi_q;
   assign dir     = dir_q;

   // R6
   restart_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.ldi_wr | acc.rdi_wr) |=> (phase == PH_RED));

   // R2
   red_then_green_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.dat_wr && !idx_load && phase == PH_RED) |=> (phase == PH_GRN));

   // R4
   load_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_en |=> (ldi_q == $past(ldi_q) + 1'b1));

   // R5
   read_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.dat_rd && phase == PH_BLU && dir_q == DIR_READ) |=> (rdi_q == $past(rdi_q) + 1'b1));

endmodule

// File: rtl/pal_store.sv
`timescale 1ns/1ps
module pal_store #(
   parameter int unsigned IDX_W   = 8,
   parameter int unsigned RGB_W   = 18,
   parameter int unsigned PIX_LAT = 1,
   localparam int unsigned DEPTH  = 1 << IDX_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  logic [RGB_W-1:0] wdata,
   input  logic [IDX_W-1:0] faddr,
   output logic [RGB_W-1:0] fdata,
   input  logic [IDX_W-1:0] pix_idx,
   output logic [RGB_W-1:0] pix_rgb
);

   logic [RGB_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
   end

   assign fdata = mem[faddr];

   generate
      if (PIX_LAT == 1) begin : g_pix_reg
         always_ff @(posedge clk) begin
            if (!rst_n)
               pix_rgb <= '0;
            else
               pix_rgb <= mem[pix_idx];
         end

         // R8
         pix_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(we) && pix_idx == $past(waddr)) |=> (pix_rgb == $past(wdata, 2)));
      end else if (PIX_LAT == 0) begin : g_pix_comb
         logic unused_rst;
         assign unused_rst = rst_n;
         assign pix_rgb = mem[pix_idx];
      end else begin : g_pix_bad
         $error("pal_store: PIX_LAT must be 0 or 1");
      end
   endgenerate

endmodule

// File: rtl/color_palette.sv
`timescale 1ns/1ps
module color_palette
   import pal_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned IDX_W   = 8,
   parameter int unsigned COMP_W  = 6,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned PIX_LAT = 1,
   parameter logic [ADDR_W-1:0] LDI_ADDR = 16'h03C8,
   parameter logic [ADDR_W-1:0] RDI_ADDR = 16'h03C7,
   parameter logic [ADDR_W-1:0] DAT_ADDR = 16'h03C9,
   localparam int unsigned RGB_W = 3 * COMP_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   input  logic [IDX_W-1:0]  pix_idx,
   output logic [RGB_W-1:0]  pix_rgb
);

   generate
      if (DATA_W < 3) begin : g_bad_data
         $error("color_palette: data byte too narrow for status field");
      end
   endgenerate

   pal_acc_t          acc;
   logic [IDX_W-1:0]  fetch_idx, commit_idx, ldi_cur;
   logic [RGB_W-1:0]  fetch_rgb, commit_rgb;
   logic              commit_en;
   dir_e              dir;
   logic [COMP_W-1:0] rd_comp;

   pal_decode #(
      .ADDR_W   (ADDR_W),
      .LDI_ADDR (LDI_ADDR),
      .RDI_ADDR (RDI_ADDR),
      .DAT_ADDR (DAT_ADDR)
   ) u_decode (
      .io_addr (io_addr),
      .io_wr   (io_wr),
      .io_rd   (io_rd),
      .acc     (acc)
   );

   pal_seq #(
      .IDX_W  (IDX_W),
      .COMP_W (COMP_W),
      .DATA_W (DATA_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc        (acc),
      .wdata      (io_wdata),
      .fetch_rgb  (fetch_rgb),
      .fetch_idx  (fetch_idx),
      .commit_en  (commit_en),
      .commit_idx (commit_idx),
      .commit_rgb (commit_rgb),
      .ldi_cur    (ldi_cur),
      .dir        (dir),
      .rd_comp    (rd_comp)
   );

   pal_store #(
      .IDX_W   (IDX_W),
      .RGB_W   (RGB_W),
      .PIX_LAT (PIX_LAT)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (commit_en),
      .waddr   (commit_idx),
      .wdata   (commit_rgb),
      .faddr   (fetch_idx),
      .fdata   (fetch_rgb),
      .pix_idx (pix_idx),
      .pix_rgb (pix_rgb)
   );

   always_comb begin
      io_rdata = '0;
      if (acc.ldi_rd)
         io_rdata[IDX_W-1:0] = ldi_cur;
      else if (acc.sts_rd)
         io_rdata[1:0] = (dir == DIR_READ) ? 2'b11 : 2'b00;
      else if (acc.dat_rd)
         io_rdata[COMP_W-1:0] = rd_comp;
   end

   // R7
   status_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc.sts_rd |-> (io_rdata[DATA_W-1:2] == '0));

endmodule

// File: tb/color_palette_test.sv
`timescale 1ns/1ps
module color_palette_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic [7:0]  pix_idx = '0;
   logic [17:0] pix_rgb;

   localparam logic [15:0] A_RDI = 16'h03C7;
   localparam logic [15:0] A_LDI = 16'h03C8;
   localparam logic [15:0] A_DAT = 16'h03C9;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } sb_item_t;

   sb_item_t sbq[$];

   always #2.5 clk = ~clk;

   color_palette uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .io_addr  (io_addr),
      .io_wr    (io_wr),
      .io_rd    (io_rd),
      .io_wdata (io_wdata),
      .io_rdata (io_rdata),
      .pix_idx  (pix_idx),
      .pix_rgb  (pix_rgb)
   );

   // monitor: compares each register read against the scoreboard head
   always @(negedge clk) begin
      if (io_rd) begin
         sb_item_t it;
         n_checks++;
         if (sbq.size() == 0) begin
            n_fail++;
            $display("FAIL %s: unexpected read, actual %02h expected none", "SB", io_rdata);
         end else begin
            it = sbq.pop_front();
            if (io_rdata !== it.exp) begin
               n_fail++;
               $display("FAIL %s: read data actual %02h expected %02h", it.tag, io_rdata, it.exp);
            end
         end
      end
   end

   task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(posedge clk); #1;
      io_wr = 1'b0;
   endtask

   task automatic do_rd(input logic [15:0] a, input logic [7:0] e, input string tag);
      sb_item_t it;
      it.exp = e; it.tag = tag;
      sbq.push_back(it);
      io_addr = a; io_rd = 1'b1;
      @(posedge clk); #1;
      io_rd = 1'b0;
   endtask

   task automatic chk_pix(input logic [17:0] e, input string tag);
      n_checks++;
      if (pix_rgb !== e) begin
         n_fail++;
         $display("FAIL %s: pix_rgb actual %05h expected %05h", tag, pix_rgb, e);
      end
   endtask

   task automatic pix_look(input logic [7:0] idx, input logic [17:0] e, input string tag);
      pix_idx = idx;
      @(posedge clk);
      @(negedge clk);
      chk_pix(e, tag);
      @(posedge clk); #1;
   endtask

   function automatic logic [17:0] rgb(input logic [5:0] r, input logic [5:0] g, input logic [5:0] b);
      return {r, g, b};
   endfunction

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         if (sbq.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL SB: %0d reads pending, expected 0", sbq.size());
         end
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_checks++; n_fail++;
      $display("FAIL WATCHDOG: run did not end, actual timeout expected completion");
      finish_up();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1: reset state
      chk_pix(18'h0, "R1");
      do_rd(A_LDI, 8'h00, "R1");
      do_rd(A_RDI, 8'h00, "R1");

      // R2: load entry 5, upper bits of each byte dropped
      do_wr(A_LDI, 8'd5);
      do_wr(A_DAT, 8'hFF);
      do_wr(A_DAT, 8'h41);
      do_wr(A_DAT, 8'h15);
      pix_look(8'd5, rgb(6'h3F, 6'h01, 6'h15), "R2");
      // R4: load index moved on
      do_rd(A_LDI, 8'd6, "R4");
      // R7: status after load-index write
      do_rd(A_RDI, 8'h00, "R7");

      // R3 / R8: entry 6 unchanged until blue, then visible one clock later
      pix_look(8'd6, 18'h0, "R3");
      do_wr(A_DAT, 8'h0A);
      pix_look(8'd6, 18'h0, "R3");
      do_wr(A_DAT, 8'h0B);
      pix_look(8'd6, 18'h0, "R3");
      do_wr(A_DAT, 8'h0C);
      chk_pix(18'h0, "R8");
      @(posedge clk); #1;
      chk_pix(rgb(6'h0A, 6'h0B, 6'h0C), "R8");

      // R4: stream across 255 -> 0
      do_wr(A_LDI, 8'd255);
      do_wr(A_DAT, 8'd1); do_wr(A_DAT, 8'd2); do_wr(A_DAT, 8'd3);
      do_wr(A_DAT, 8'd4); do_wr(A_DAT, 8'd5); do_wr(A_DAT, 8'd6);
      do_rd(A_LDI, 8'd1, "R4");
      pix_look(8'd255, rgb(6'd1, 6'd2, 6'd3), "R4");
      pix_look(8'd0,   rgb(6'd4, 6'd5, 6'd6), "R4");

      // R5: read back entries 5 and 6 in sequence
      do_wr(A_RDI, 8'd5);
      do_rd(A_RDI, 8'h03, "R7");
      do_rd(A_DAT, 8'h3F, "R5"); do_rd(A_DAT, 8'h01, "R5"); do_rd(A_DAT, 8'h15, "R5");
      do_rd(A_DAT, 8'h0A, "R5"); do_rd(A_DAT, 8'h0B, "R5"); do_rd(A_DAT, 8'h0C, "R5");
      // R5: read-back wrap
      do_wr(A_RDI, 8'd255);
      do_rd(A_DAT, 8'd1, "R5"); do_rd(A_DAT, 8'd2, "R5"); do_rd(A_DAT, 8'd3, "R5");
      do_rd(A_DAT, 8'd4, "R5"); do_rd(A_DAT, 8'd5, "R5"); do_rd(A_DAT, 8'd6, "R5");

      // R6: restart mid-triplet on load side
      do_wr(A_LDI, 8'd10);
      do_wr(A_DAT, 8'h11);
      do_wr(A_LDI, 8'd20);
      do_wr(A_DAT, 8'd7); do_wr(A_DAT, 8'd8); do_wr(A_DAT, 8'd9);
      pix_look(8'd20, rgb(6'd7, 6'd8, 6'd9), "R6");
      pix_look(8'd10, 18'h0, "R6");
      // R6: restart mid-triplet on read side
      do_wr(A_RDI, 8'd5);
      do_rd(A_DAT, 8'h3F, "R6");
      do_wr(A_RDI, 8'd5);
      do_rd(A_DAT, 8'h3F, "R6");

      // R9: data writes in read direction do not commit
      do_wr(A_LDI, 8'd7);
      do_wr(A_DAT, 8'h31); do_wr(A_DAT, 8'h32); do_wr(A_DAT, 8'h33);
      do_wr(A_RDI, 8'd6);
      do_wr(A_DAT, 8'h21); do_wr(A_DAT, 8'h22); do_wr(A_DAT, 8'h23);
      pix_look(8'd6, rgb(6'h0A, 6'h0B, 6'h0C), "R9");
      do_rd(A_DAT, 8'h31, "R9"); do_rd(A_DAT, 8'h32, "R9"); do_rd(A_DAT, 8'h33, "R9");
      do_rd(A_LDI, 8'd8, "R9");

      // R10: unmapped offsets
      do_wr(16'h03C6, 8'h55);
      do_rd(16'h03C6, 8'h00, "R10");
      do_rd(16'h03CA, 8'h00, "R10");
      do_rd(A_RDI, 8'h03, "R10");
      do_rd(A_LDI, 8'd8, "R10");

      repeat (2) @(posedge clk);
      #1;
      finish_up();
   end

endmodule